// File: doc/BRIEF.md
# SHA-512 Dual-Round Compression Datapath

This block performs two consecutive SHA-512 compression rounds in a single registered step. The work is split into two operations chosen by a one-bit opcode. The choose operation advances the lower half of the working state (the words usually called E through H) with the Ch function and the Sigma1 rotation network. The majority operation advances the upper half (A through D) with the Maj function and the Sigma0 network.

Each operation takes three 128-bit operands. Each operand carries two 64-bit lanes. The operation returns one 128-bit result. Inside one operation the two rounds depend on each other: the upper-lane result is computed first, and it then feeds the lower-lane computation in the same cycle.

A sequencer outside this block handles the rest of the hash: padding, round constants, the 80-round schedule and the digest accumulation. It supplies the operands with the message word and the round constant already added, and it pulses `in_valid`. The result appears on the next clock edge together with `out_valid`.

Top module: `sha512_dual_round`

## Requirements
- R1: With opcode 0, result lane 1 equals Ch(y1, x0, x1) + S1(y1) + w1. Here Ch(e,f,g) = (e AND f) XOR (NOT e AND g), and S1(v) is the XOR of v rotated right by 14, by 18 and by 41 bits.
- R2: With opcode 0, the block forms t = (result lane 1) + y0. Result lane 0 then equals Ch(t, y1, x0) + S1(t) + w0.
- R3: With opcode 1, result lane 1 equals Maj(y1, x0, y0) + S0(y0) + w1. Here Maj is the bitwise majority of its three inputs, and S0(v) is the XOR of v rotated right by 28, by 34 and by 39 bits.
- R4: With opcode 1, result lane 0 equals Maj(r1, y0, y1) + S0(r1) + w0, where r1 is the lane 1 result of the same operation.
- R5: Every sum wraps modulo 2^64, and no carry passes from lane 0 into lane 1.
- R6: Lane 0 is bits [63:0] and lane 1 is bits [127:64] of every operand and of the result.
- R7: `in_op` = 0 selects the Ch/S1 operation and `in_op` = 1 selects the Maj/S0 operation. The opcode is sampled together with the operands.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise.
- R9: While `rst` is high at a clock edge, `out_valid` and `out_res` are cleared to zero on that edge.
- R10: When `in_valid` is low, `out_res` keeps its previous value, whatever the operand and opcode inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| in_op | input | 1 | 0 = Ch/Sigma1 rounds, 1 = Maj/Sigma0 rounds |
| in_w | input | 128 | Operand w (round input plus constant, two lanes) |
| in_x | input | 128 | Operand x (two state words) |
| in_y | input | 128 | Operand y (two state words) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_res | output | 128 | Two-lane result |

## Verification
The bench drives all-ones operands so that every sum overflows. A design that let a carry cross from lane 0 into lane 1, or kept a 65th bit, gives a wrong upper lane there. Single-bit operands placed in one lane at a time expose swapped lanes and mixed-up rotation amounts. A design that fed the old y1, rather than the new lane 1 value, into the second round differs from the model in lane 0 only, and lane 0 is compared on its own.

Operands keep changing while `in_valid` is low, and a reset is applied in the middle of traffic while `in_valid` stays high. A result register that loads without `in_valid`, or a valid flag that survives reset, is therefore caught at once.

// File: rtl/sha512_dual_round_pkg.sv
package sha512_dual_round_pkg;

    localparam int LANE_W = 64;
    localparam int PAIR_W = 2 * LANE_W;

    // rotation amounts of the two big-sigma networks
    localparam int S1_RA = 14;
    localparam int S1_RB = 18;
    localparam int S1_RC = 41;
    localparam int S0_RA = 28;
    localparam int S0_RB = 34;
    localparam int S0_RC = 39;

    typedef logic [LANE_W-1:0] lane_t;

    // hi is lane 1 (upper bits), lo is lane 0
    typedef struct packed {
        lane_t hi;
        lane_t lo;
    } pair_t;

    typedef struct packed {
        logic  vld;
        pair_t res;
    } stage_t;

    function automatic lane_t rotr(input lane_t v, input int n);
        return (v >> n) | (v << (LANE_W - n));
    endfunction

endpackage

// File: rtl/sha512_bigsig.sv
module sha512_bigsig
    import sha512_dual_round_pkg::*;
#(
    parameter bit USE_S1 = 1'b1
) (
    input  lane_t v,
    output lane_t s
);
    generate
        if (USE_S1) begin : g_s1
            assign s = rotr(v, S1_RA) ^ rotr(v, S1_RB) ^ rotr(v, S1_RC);
        end else begin : g_s0
            assign s = rotr(v, S0_RA) ^ rotr(v, S0_RB) ^ rotr(v, S0_RC);
        end
    endgenerate
endmodule

// File: rtl/sha512_ch_pair.sv
module sha512_ch_pair
    import sha512_dual_round_pkg::*;
(
    input  pair_t w,
    input  pair_t x,
    input  pair_t y,
    output pair_t r
);
    lane_t sig_hi;
    lane_t sig_lo;
    lane_t first;
    lane_t mid;

    sha512_bigsig #(.USE_S1(1'b1)) u_sig_hi (.v(y.hi), .s(sig_hi));

    // first round, then the chained value that drives the second round
    always_comb begin
        first = ((y.hi & x.lo) ^ (~y.hi & x.hi)) + sig_hi + w.hi;
        mid   = first + y.lo;
    end

    sha512_bigsig #(.USE_S1(1'b1)) u_sig_lo (.v(mid), .s(sig_lo));

    always_comb begin
        r.hi = first;
        r.lo = ((mid & y.hi) ^ (~mid & x.lo)) + sig_lo + w.lo;
    end
endmodule

// File: rtl/sha512_maj_pair.sv
module sha512_maj_pair
    import sha512_dual_round_pkg::*;
(
    input  pair_t w,
    input  lane_t x_lo,
    input  pair_t y,
    output pair_t r
);
    lane_t sig_hi;
    lane_t sig_lo;
    lane_t first;

    sha512_bigsig #(.USE_S1(1'b0)) u_sig_hi (.v(y.lo), .s(sig_hi));

    always_comb begin
        first = ((y.hi & x_lo) ^ (y.lo & x_lo) ^ (y.hi & y.lo)) + sig_hi + w.hi;
    end

    sha512_bigsig #(.USE_S1(1'b0)) u_sig_lo (.v(first), .s(sig_lo));

    always_comb begin
        r.hi = first;
        r.lo = ((first & y.lo) ^ (first & y.hi) ^ (y.hi & y.lo)) + sig_lo + w.lo;
    end
endmodule

// File: rtl/sha512_dual_round.sv
module sha512_dual_round
    import sha512_dual_round_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic [PAIR_W-1:0] in_w,
    input  logic [PAIR_W-1:0] in_x,
    input  logic [PAIR_W-1:0] in_y,
    output logic              out_valid,
    output logic [PAIR_W-1:0] out_res
);
    pair_t  w_p, x_p, y_p;
    pair_t  ch_r, maj_r;
    stage_t st_d, st_q;

    assign w_p = pair_t'(in_w);
    assign x_p = pair_t'(in_x);
    assign y_p = pair_t'(in_y);

    sha512_ch_pair u_ch (
        .w (w_p),
        .x (x_p),
        .y (y_p),
        .r (ch_r)
    );

    sha512_maj_pair u_maj (
        .w    (w_p),
        .x_lo (x_p.lo),
        .y    (y_p),
        .r    (maj_r)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = in_op ? maj_r : ch_r;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_res   = st_q.res;
endmodule

// File: rtl/sha512_dual_round_chk.sv
module sha512_dual_round_chk
    import sha512_dual_round_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_op,
    input logic [PAIR_W-1:0] in_w,
    input logic [PAIR_W-1:0] in_x,
    input logic [PAIR_W-1:0] in_y,
    input logic              out_valid,
    input logic [PAIR_W-1:0] out_res
);
    function automatic lane_t s1f(input lane_t v);
        return {v[13:0], v[63:14]} ^ {v[17:0], v[63:18]} ^ {v[40:0], v[63:41]};
    endfunction
    function automatic lane_t s0f(input lane_t v);
        return {v[27:0], v[63:28]} ^ {v[33:0], v[63:34]} ^ {v[38:0], v[63:39]};
    endfunction

    lane_t c1, ct, c0, m1, m0;
    always_comb begin
        c1 = ((in_y[127:64] & in_x[63:0]) | (~in_y[127:64] & in_x[127:64]))
             + s1f(in_y[127:64]) + in_w[127:64];
        ct = c1 + in_y[63:0];
        c0 = ((ct & in_y[127:64]) | (~ct & in_x[63:0])) + s1f(ct) + in_w[63:0];
        m1 = ((in_y[127:64] & in_x[63:0]) | (in_y[63:0] & (in_y[127:64] | in_x[63:0])))
             + s0f(in_y[63:0]) + in_w[127:64];
        m0 = ((m1 & in_y[63:0]) | (in_y[127:64] & (m1 | in_y[63:0])))
             + s0f(m1) + in_w[63:0];
    end

    p_ch_hi_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op) |=> out_res[127:64] == $past(c1));
    p_ch_lo_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op) |=> out_res[63:0] == $past(c0));
    p_maj_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op) |=> out_res[127:64] == $past(m1));
    p_maj_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op) |=> out_res[63:0] == $past(m0));
    p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_low_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_res == '0));
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_res));
endmodule

bind sha512_dual_round sha512_dual_round_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_w      (in_w),
    .in_x      (in_x),
    .in_y      (in_y),
    .out_valid (out_valid),
    .out_res   (out_res)
);

// File: tb/sim_sha512_dual_round.sv
`timescale 1ns/1ps
module sim_sha512_dual_round;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_op = 1'b0;
    logic [127:0] in_w = '0, in_x = '0, in_y = '0;
    logic         out_valid;
    logic [127:0] out_res;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic         exp_valid = 1'b0;
    logic [127:0] exp_res = '0;
    string        exp_tag = "R9";

    always #10 clk = ~clk;

    sha512_dual_round u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_w(in_w), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_res(out_res)
    );

    function automatic logic [63:0] rr(input logic [63:0] v, input int n);
        logic [127:0] d;
        d = {v, v} >> n;
        return d[63:0];
    endfunction

    function automatic logic [63:0] add3(input logic [63:0] a, b, c);
        logic [65:0] s;
        s = {2'b0, a} + {2'b0, b} + {2'b0, c};
        return s[63:0];
    endfunction

    function automatic logic [127:0] model(input logic op, input logic [127:0] w, x, y);
        logic [63:0] w1, w0, x1, x0, y1, y0, a, t, b, e, f;
        {w1, w0} = w; {x1, x0} = x; {y1, y0} = y;
        if (!op) begin
            e = rr(y1, 14) ^ rr(y1, 18) ^ rr(y1, 41);
            a = add3((y1 & x0) ^ (~y1 & x1), e, w1);
            t = add3(a, y0, 64'd0);
            f = rr(t, 14) ^ rr(t, 18) ^ rr(t, 41);
            b = add3((t & y1) ^ (~t & x0), f, w0);
        end else begin
            e = rr(y0, 28) ^ rr(y0, 34) ^ rr(y0, 39);
            a = add3((y1 & x0) ^ (y1 & y0) ^ (x0 & y0), e, w1);
            f = rr(a, 28) ^ rr(a, 34) ^ rr(a, 39);
            b = add3((a & y0) ^ (a & y1) ^ (y0 & y1), f, w0);
        end
        return {b, a} == {b, a} ? {a, b} : '0;
    endfunction

    // compare outputs with the model, then apply new inputs and advance the model
    task automatic step(input logic r, input logic v, input logic op,
                        input logic [127:0] w, x, y, input string tag);
        @(negedge clk);
        total++;
        if (out_valid !== exp_valid) begin
            bad++;
            $display("FAIL %s/R8 out_valid actual=%0b expected=%0b", exp_tag, out_valid, exp_valid);
        end
        total++;
        if (out_res !== exp_res) begin
            bad++;
            $display("FAIL %s out_res actual=%h expected=%h", exp_tag, out_res, exp_res);
        end
        rst = r; in_valid = v; in_op = op; in_w = w; in_x = x; in_y = y;
        if (r) begin
            exp_valid = 1'b0; exp_res = '0; exp_tag = "R9";
        end else begin
            exp_valid = v;
            if (v) begin
                exp_res = model(op, w, x, y);
                exp_tag = tag;
            end else begin
                exp_tag = "R10";
            end
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #4_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] ones;
        ones = '1;
        // R9: valid high while in reset must not propagate
        step(1, 1, 0, ones, ones, ones, "R9");
        step(1, 1, 1, ones, ones, ones, "R9");
        // R1 R2 R7 basic
        step(0, 1, 0, '0, '0, '0, "R1/R2");
        step(0, 1, 1, '0, '0, '0, "R3/R4");
        // R5 wrap: all ones everywhere
        step(0, 1, 0, ones, ones, ones, "R5");
        step(0, 1, 1, ones, ones, ones, "R5");
        // R6 lane placement: single bits in one lane at a time
        for (int i = 0; i < 4; i++) begin
            step(0, 1, i[0], 128'd1 << (i * 37), 128'd1 << 64, 128'd1 << (64 + i), "R6");
            step(0, 1, i[0], '0, '0, 128'd1 << (i * 9 + 3), "R6");
        end
        // R10: inputs change while valid is low
        step(0, 1, 1, rnd128(), rnd128(), rnd128(), "R3/R4");
        for (int i = 0; i < 5; i++) step(0, 0, i[0], rnd128(), rnd128(), rnd128(), "R10");
        // R7 same operands, both opcodes back to back
        begin
            logic [127:0] a, b, c;
            a = rnd128(); b = rnd128(); c = rnd128();
            step(0, 1, 0, a, b, c, "R7");
            step(0, 1, 1, a, b, c, "R7");
        end
        // random traffic with gaps
        for (int i = 0; i < 300; i++) begin
            logic v, o;
            v = ($urandom % 4) != 0;
            o = $urandom % 2;
            step(0, v, o, rnd128(), rnd128(), rnd128(), o ? "R3/R4" : "R1/R2");
        end
        // R9 reset mid-traffic with valid held high
        step(1, 1, 0, rnd128(), rnd128(), rnd128(), "R9");
        step(0, 0, 0, rnd128(), rnd128(), rnd128(), "R10");
        step(0, 1, 1, rnd128(), rnd128(), rnd128(), "R3/R4");
        step(0, 0, 0, '0, '0, '0, "R8");
        step(0, 0, 0, '0, '0, '0, "R8");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule